// File: doc/BRIEF.md
# Two-Road Traffic Controller with Left-Turn Phases

The block drives the lamps of one intersection where a main road A meets a side road B. Each road has four lamps: red, yellow, straight green and a left-turn arrow. The controller steps through eight coordinated phases. Road A first runs green, yellow, left arrow and yellow while B stays red. Road B then runs the same four steps while A stays red. Both roads share a 120 s period. Road B's red lasts 10 s longer than A's, and its green 10 s shorter.

A clock divider turns the system clock into a one-cycle timing strobe once per second; it is not a derived clock. The number of system clocks per second is a parameter, so a simulation can use a small value. On each strobe, each road's remaining time counts down as two packed BCD digits. Each count runs from the phase duration down to 01. On the strobe where the count stands at 01, the next phase's duration loads. Four combinational decoders turn the countdown digits into active-low seven-segment patterns for display.

Top module: `tlc_ctrl`

## Requirements
- R1: While rst_ni is low, and after its release until the first second strobe, both lamp outputs are 4'b1000 (red), both countdowns are 8'h00, and all four segment outputs are 8'hC0.
- R2: Each lamp output is always one-hot, with red = 4'b1000, straight green = 4'b0100, yellow = 4'b0010 and left arrow = 4'b0001.
- R3: Road A shows, in order, green for GRN_A_S (40) seconds, then yellow for YEL_S (5), then left arrow for LFT_A_S (15), then yellow for YEL_S (5), then red for RED_A_S (55), and then repeats.
- R4: Road B shows, in order, red for RED_B_S (65) seconds, then green for GRN_B_S (30), then yellow for YEL_S (5), then left arrow for LFT_B_S (15), then yellow for YEL_S (5), and then repeats.
- R5: The two roads are never both showing a lamp other than red at the same time.
- R6: Each countdown is packed BCD with the tens digit in bits 7:4 and the units digit in bits 3:0, and both digits are at most 9. Each strobe lowers the count by one: a units digit of 0 becomes 9 and the tens digit drops by one. A phase shows its duration first and 01 last.
- R7: The second strobe occurs on every DIV_CNT-th rising clock edge after reset release. Lamps and countdowns change only on that edge.
- R8: Each segment output is the active-low pattern for its digit. For digits 0 to F the patterns are C0, F9, A4, B0, 99, 92, 82, F8, 80, 90, 88, 83, C6, A1, 86, 8E. The digits are the tens and units of road A (seg_a_hi_o, seg_a_lo_o) and of road B (seg_b_hi_o, seg_b_lo_o).
- R9: The first strobe after reset starts the cycle: road A shows green with 8'h40, and road B shows red with 8'h65.
- R10: Each road's red time equals the sum of the other road's four active phases. The two countdowns therefore reach 01 on the same strobe at both hand-over points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lamp_a_o | output | 4 | Road A lamps, one-hot |
| lamp_b_o | output | 4 | Road B lamps, one-hot |
| cnt_a_o | output | 8 | Road A remaining seconds, packed BCD |
| cnt_b_o | output | 8 | Road B remaining seconds, packed BCD |
| seg_a_hi_o | output | 8 | Road A tens digit, active-low segments |
| seg_a_lo_o | output | 8 | Road A units digit, active-low segments |
| seg_b_hi_o | output | 8 | Road B tens digit, active-low segments |
| seg_b_lo_o | output | 8 | Road B units digit, active-low segments |

## Verification
The assertions assume that the duration parameters are between 1 and 99 seconds and that the red times match the opposing active sums; the hand-over property exists to catch a mismatch. The only input stimulus is reset, and the assertions assume it is released away from a clock edge. The bench drives reset at falling edges. It uses a fixed-seed random choice of reset lengths and run lengths, so reset lands mid-phase, mid-digit and at the startup point.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LAMP_W = 4;
  localparam int PH_W   = 3;
  localparam logic [LAMP_W-1:0] LAMP_RED = 4'b1000;
  localparam logic [LAMP_W-1:0] LAMP_GRN = 4'b0100;
  localparam logic [LAMP_W-1:0] LAMP_YEL = 4'b0010;
  localparam logic [LAMP_W-1:0] LAMP_LFT = 4'b0001;

  function automatic logic [7:0] to_bcd(input int d);
    return {4'((d / 10) % 10), 4'(d % 10)};
  endfunction

  function automatic logic [7:0] bcd_dec(input logic [7:0] v);
    if (v[3:0] == 4'd0) return {v[7:4] - 4'd1, 4'd9};
    return {v[7:4], v[3:0] - 4'd1};
  endfunction
endpackage

// File: rtl/tlc_tick_div.sv
module tlc_tick_div #(
  parameter int DIV_CNT = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV_CNT > 1) ? $clog2(DIV_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_CNT - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R7: the counter never passes its terminal value
  assert_div_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
  import tlc_pkg::*;
#(
  parameter int GRN_A_S = 40,
  parameter int LFT_A_S = 15,
  parameter int GRN_B_S = 30,
  parameter int LFT_B_S = 15,
  parameter int YEL_S   = 5,
  parameter int RED_A_S = 55,
  parameter int RED_B_S = 65
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [LAMP_W-1:0] lamp_a_o,
  output logic [LAMP_W-1:0] lamp_b_o,
  output logic [7:0]        cnt_a_o,
  output logic [7:0]        cnt_b_o
);
  localparam logic [7:0] BCD_ONE = 8'h01;

  logic [PH_W-1:0] phase_q, phase_nxt;
  logic            run_q;
  logic [7:0]      cnt_a_q, cnt_b_q, def_cnt;

  function automatic int dur_a(input logic [PH_W-1:0] p);
    case (p)
      3'd0:       return GRN_A_S;
      3'd1, 3'd3: return YEL_S;
      3'd2:       return LFT_A_S;
      default:    return RED_A_S;
    endcase
  endfunction

  function automatic int dur_b(input logic [PH_W-1:0] p);
    case (p)
      3'd4:       return GRN_B_S;
      3'd5, 3'd7: return YEL_S;
      3'd6:       return LFT_B_S;
      default:    return RED_B_S;
    endcase
  endfunction

  function automatic logic [LAMP_W-1:0] lamp_of(input logic [1:0] step, input logic active);
    if (!active) return LAMP_RED;
    case (step)
      2'd0:       return LAMP_GRN;
      2'd2:       return LAMP_LFT;
      default:    return LAMP_YEL;
    endcase
  endfunction

  assign phase_nxt = phase_q + 1'b1;
  // phases 0..3 are timed by road A, 4..7 by road B
  assign def_cnt   = phase_q[2] ? cnt_b_q : cnt_a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      run_q   <= 1'b0;
      cnt_a_q <= '0;
      cnt_b_q <= '0;
    end else if (tick_i) begin
      if (!run_q) begin
        run_q   <= 1'b1;
        cnt_a_q <= to_bcd(dur_a(phase_q));
        cnt_b_q <= to_bcd(dur_b(phase_q));
      end else begin
        if (def_cnt == BCD_ONE) phase_q <= phase_nxt;
        cnt_a_q <= (cnt_a_q == BCD_ONE) ? to_bcd(dur_a(phase_nxt)) : bcd_dec(cnt_a_q);
        cnt_b_q <= (cnt_b_q == BCD_ONE) ? to_bcd(dur_b(phase_nxt)) : bcd_dec(cnt_b_q);
      end
    end
  end

  assign lamp_a_o = lamp_of(phase_q[1:0], run_q & ~phase_q[2]);
  assign lamp_b_o = lamp_of(phase_q[1:0], run_q &  phase_q[2]);
  assign cnt_a_o  = cnt_a_q;
  assign cnt_b_o  = cnt_b_q;

  assert_lamp_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(lamp_a_o) && $onehot(lamp_b_o));

  assert_no_conflict_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_a_o == LAMP_RED) || (lamp_b_o == LAMP_RED));

  assert_bcd_digits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_a_q[3:0] <= 4'd9) && (cnt_a_q[7:4] <= 4'd9) &&
    (cnt_b_q[3:0] <= 4'd9) && (cnt_b_q[7:4] <= 4'd9));

  assert_hold_between_ticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_a_q) && $stable(cnt_b_q) && $stable(phase_q));

  assert_red_sum_a_to_b_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && phase_q == 3'd3 && cnt_a_q == BCD_ONE) |-> (cnt_b_q == BCD_ONE));

  assert_red_sum_b_to_a_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && phase_q == 3'd7 && cnt_b_q == BCD_ONE) |-> (cnt_a_q == BCD_ONE));
endmodule

// File: rtl/tlc_seg_dec.sv
module tlc_seg_dec (
  input  logic [3:0] digit_i,
  output logic [7:0] seg_no
);
  always_comb begin
    case (digit_i)
      4'h0: seg_no = 8'hC0;
      4'h1: seg_no = 8'hF9;
      4'h2: seg_no = 8'hA4;
      4'h3: seg_no = 8'hB0;
      4'h4: seg_no = 8'h99;
      4'h5: seg_no = 8'h92;
      4'h6: seg_no = 8'h82;
      4'h7: seg_no = 8'hF8;
      4'h8: seg_no = 8'h80;
      4'h9: seg_no = 8'h90;
      4'hA: seg_no = 8'h88;
      4'hB: seg_no = 8'h83;
      4'hC: seg_no = 8'hC6;
      4'hD: seg_no = 8'hA1;
      4'hE: seg_no = 8'h86;
      default: seg_no = 8'h8E;
    endcase
  end
endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
#(
  parameter int DIV_CNT = 50_000_000,
  parameter int GRN_A_S = 40,
  parameter int LFT_A_S = 15,
  parameter int GRN_B_S = 30,
  parameter int LFT_B_S = 15,
  parameter int YEL_S   = 5,
  parameter int RED_A_S = 55,
  parameter int RED_B_S = 65
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [3:0] lamp_a_o,
  output logic [3:0] lamp_b_o,
  output logic [7:0] cnt_a_o,
  output logic [7:0] cnt_b_o,
  output logic [7:0] seg_a_hi_o,
  output logic [7:0] seg_a_lo_o,
  output logic [7:0] seg_b_hi_o,
  output logic [7:0] seg_b_lo_o
);
  localparam int NDIG = 4;

  logic             tick;
  logic [NDIG-1:0][3:0] digits;
  logic [NDIG-1:0][7:0] segs;

  tlc_tick_div #(.DIV_CNT(DIV_CNT)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  tlc_phase_fsm #(
    .GRN_A_S(GRN_A_S), .LFT_A_S(LFT_A_S),
    .GRN_B_S(GRN_B_S), .LFT_B_S(LFT_B_S),
    .YEL_S(YEL_S), .RED_A_S(RED_A_S), .RED_B_S(RED_B_S)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .lamp_a_o(lamp_a_o),
    .lamp_b_o(lamp_b_o),
    .cnt_a_o (cnt_a_o),
    .cnt_b_o (cnt_b_o)
  );

  assign digits = {cnt_b_o[3:0], cnt_b_o[7:4], cnt_a_o[3:0], cnt_a_o[7:4]};

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    tlc_seg_dec u_dec (.digit_i(digits[g]), .seg_no(segs[g]));
  end

  assign seg_a_hi_o = segs[0];
  assign seg_a_lo_o = segs[1];
  assign seg_b_hi_o = segs[2];
  assign seg_b_lo_o = segs[3];
endmodule

// File: tb/tlc_ctrl_bench.sv
module tlc_ctrl_bench;
  localparam int DIV = 4;
  localparam int PERIOD = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] lamp_a, lamp_b;
  logic [7:0] cnt_a, cnt_b, sah, sal, sbh, sbl;

  int n_vec = 0, n_bad = 0;
  int pcount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlc_ctrl #(.DIV_CNT(DIV)) u_tlc_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .lamp_a_o(lamp_a), .lamp_b_o(lamp_b),
    .cnt_a_o(cnt_a), .cnt_b_o(cnt_b),
    .seg_a_hi_o(sah), .seg_a_lo_o(sal),
    .seg_b_hi_o(sbh), .seg_b_lo_o(sbl)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) pcount <= 0;
    else        pcount <= pcount + 1;

  function automatic logic [7:0] seg_ref(input logic [3:0] d);
    logic [7:0] t [16] = '{8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99, 8'h92, 8'h82, 8'hF8,
                           8'h80, 8'h90, 8'h88, 8'h83, 8'hC6, 8'hA1, 8'h86, 8'h8E};
    return t[d];
  endfunction

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // expected lamp and remaining seconds for t seconds into the cycle
  function automatic void ref_a(input int t, output logic [3:0] l, output int r);
    if      (t < 40) begin l = 4'b0100; r = 40 - t;  end
    else if (t < 45) begin l = 4'b0010; r = 45 - t;  end
    else if (t < 60) begin l = 4'b0001; r = 60 - t;  end
    else if (t < 65) begin l = 4'b0010; r = 65 - t;  end
    else             begin l = 4'b1000; r = 120 - t; end
  endfunction

  function automatic void ref_b(input int t, output logic [3:0] l, output int r);
    if      (t < 65)  begin l = 4'b1000; r = 65 - t;  end
    else if (t < 95)  begin l = 4'b0100; r = 95 - t;  end
    else if (t < 100) begin l = 4'b0010; r = 100 - t; end
    else if (t < 115) begin l = 4'b0001; r = 115 - t; end
    else              begin l = 4'b0010; r = 120 - t; end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (tick %0d)", req, what, act, exp, pcount / DIV);
    end
  endtask

  task automatic check_now();
    int n = pcount / DIV;
    logic [3:0] la, lb;
    int ra, rb;
    if (!rst_n || n == 0) begin
      chk(lamp_a == 4'b1000, "R1", "lamp_a", 8'(lamp_a), 8'h08);
      chk(lamp_b == 4'b1000, "R1", "lamp_b", 8'(lamp_b), 8'h08);
      chk(cnt_a == 8'h00, "R1", "cnt_a", cnt_a, 8'h00);
      chk(cnt_b == 8'h00, "R1", "cnt_b", cnt_b, 8'h00);
      chk(sah == 8'hC0 && sbl == 8'hC0, "R1", "seg", sah, 8'hC0);
      return;
    end
    ref_a((n - 1) % PERIOD, la, ra);
    ref_b((n - 1) % PERIOD, lb, rb);
    chk(lamp_a == la, "R3", "lamp_a", 8'(lamp_a), 8'(la));
    chk(cnt_a == bcd(ra), "R3", "cnt_a", cnt_a, bcd(ra));
    chk(lamp_b == lb, "R4", "lamp_b", 8'(lamp_b), 8'(lb));
    chk(cnt_b == bcd(rb), "R4", "cnt_b", cnt_b, bcd(rb));
    chk($onehot(lamp_a) && $onehot(lamp_b), "R2", "onehot", {lamp_a, lamp_b}, 8'h00);
    chk(lamp_a == 4'b1000 || lamp_b == 4'b1000, "R5", "conflict", {lamp_a, lamp_b}, 8'h00);
    chk(cnt_a[3:0] <= 9 && cnt_a[7:4] <= 9 && cnt_b[3:0] <= 9 && cnt_b[7:4] <= 9,
        "R6", "bcd digits", cnt_a, cnt_b);
    chk(sah == seg_ref(cnt_a[7:4]), "R8", "seg_a_hi", sah, seg_ref(cnt_a[7:4]));
    chk(sal == seg_ref(cnt_a[3:0]), "R8", "seg_a_lo", sal, seg_ref(cnt_a[3:0]));
    chk(sbh == seg_ref(cnt_b[7:4]), "R8", "seg_b_hi", sbh, seg_ref(cnt_b[7:4]));
    chk(sbl == seg_ref(cnt_b[3:0]), "R8", "seg_b_lo", sbl, seg_ref(cnt_b[3:0]));
    if (n == 1) begin
      chk(cnt_a == 8'h40 && lamp_a == 4'b0100, "R9", "start a", cnt_a, 8'h40);
      chk(cnt_b == 8'h65 && lamp_b == 4'b1000, "R9", "start b", cnt_b, 8'h65);
    end
    if ((n - 1) % PERIOD == 64 || (n - 1) % PERIOD == 119)
      chk(cnt_a == 8'h01 && cnt_b == 8'h01, "R10", "handover", cnt_a, cnt_b);
  endtask

  // R7: outputs are only allowed to move on strobe edges; checked on each falling edge
  logic [7:0] prev_a, prev_b;
  int prev_n;
  task automatic check_hold();
    int n = pcount / DIV;
    if (rst_n && n == prev_n && n > 0)
      chk(cnt_a == prev_a && cnt_b == prev_b, "R7", "hold", cnt_a, prev_a);
    prev_a = cnt_a; prev_b = cnt_b; prev_n = n;
  endtask

  initial begin
    int seed = 17;
    void'($urandom(seed));
    prev_n = -1; prev_a = 0; prev_b = 0;
    for (int round = 0; round < 5; round++) begin
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 1 + int'($urandom_range(4)); i++) begin
        @(negedge clk);
        check_now();
      end
      rst_n = 1'b1;
      prev_n = -1;
      begin
        int len = (round == 0) ? (PERIOD * DIV * 2 + 40) : 50 + int'($urandom_range(900));
        for (int c = 0; c < len; c++) begin
          @(negedge clk);
          check_now();
          check_hold();
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule